// File: doc/BRIEF.md
# Dual-Channel Auxiliary PWM Unit

This block drives two edge-aligned pulse-width-modulated outputs from 16-bit counters. Each channel has its own period and duty values, and a single control bit picks how the pair relates. In independent mode each channel counts over its own period. In offset mode both channels use channel 0's period, and channel 1's cycle begins a programmable number of clocks after channel 0's.

Software writes a shadow copy of each value through a simple write port. A channel copies its shadow values into its active registers only when its counter wraps, so a cycle in progress always finishes with the values it started with. The unit marks the start of every channel 0 cycle with a sync output and a sticky interrupt flag. A fault input forces both outputs low at once. The fault is latched, and the outputs stay low until software clears the latch. The counters keep running during the fault, so the outputs come back in the correct phase.

Top module: `auxPwmPair`

## Requirements
- R1: While reset is held, both outputs and the interrupt are low and sync is high. All counters and registers reset to zero, so a zero duty keeps the outputs low after release.
- R2: Write addresses: 0 is control, 1 is period 0, 2 is duty 0, 3 is period 1, 4 is duty 1, 5 is the offset. In the control word, bit 4 selects the mode (0 independent, 1 offset), writing 1 to bit 0 clears the interrupt, and writing 1 to bit 1 clears the trip latch. Period, duty and offset writes go to shadow registers.
- R3: A channel with active period P counts 0 to P, so its cycle lasts P+1 clocks. Its output is high exactly while the count is below the active duty D. D=0 gives a constant low and D>P gives a constant high.
- R4: A channel copies its shadow values into its active registers on the edge where its counter wraps to zero. A value written part-way through a cycle leaves the rest of that cycle unchanged.
- R5: In independent mode, channel 1 runs on its own period and duty. Its output repeats every period-1-plus-one clocks and is high for min(duty, period+1) clocks of each cycle.
- R6: In offset mode, channel 1 uses channel 0's active period and its own duty. Its count is zero exactly when channel 0's count equals the active offset O. For O ≤ P, k clocks after channel 0's count is zero, channel 1 is high when ((k−O) mod (P+1)) < duty 1. The offset shadow loads on channel 0's wrap.
- R7: The sync output is high exactly while channel 0's count is zero.
- R8: The interrupt is set on the edge where channel 0 wraps. It stays set until a control write with bit 0 set. If a wrap and a clear land on the same edge, the wrap wins.
- R9: While the trip input is high, both outputs are low in that same cycle. The trip also sets a latch that keeps both outputs low after the input falls, until a control write with bit 1 set.
- R10: During a shutdown the counters and the sync output keep running. After the latch is cleared, the outputs follow the same phase as if no shutdown had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| tripIn | input | 1 | Fault shutdown input, active high |
| pwm0 | output | 1 | Channel 0 PWM output |
| pwm1 | output | 1 | Channel 1 PWM output |
| syncOut | output | 1 | High while channel 0's count is zero |
| irqOut | output | 1 | Sticky cycle-start interrupt flag |

## Verification
A counter that drifts or wraps at the wrong count shows up within one channel 0 cycle, as sync pulses spaced differently from P+1 clocks. A wrong active duty or a shadow value loaded at the wrong moment changes how many clocks the output is high in the very next cycle. In offset mode, a wrong restart point for channel 1 shifts its high window against sync, and this is visible in the first full cycle after the values settle. A trip latch that sticks or clears early keeps the outputs low, or lets them rise, in the first cycle after the clear write or after the trip input falls.

// File: rtl/auxPwmPkg.sv
`timescale 1ns/1ps
package auxPwmPkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_PER0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_DUTY0 = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PER1  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DUTY1 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_OFFS  = 3'd5;

  localparam int BIT_CLR_IRQ  = 0;
  localparam int BIT_CLR_TRIP = 1;
  localparam int BIT_MODE     = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic offsetMode;
    logic shutdown;
  } auxCtl_t;
endpackage

// File: rtl/auxPwmCtrl.sv
`timescale 1ns/1ps
module auxPwmCtrl
  import auxPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CNT_W-1:0]      wrData,
  input  logic                  tripIn,
  input  logic                  leadWrap,
  output auxCtl_t               ctl,
  output logic [CNT_W-1:0]      shPer [2],
  output logic [CNT_W-1:0]      shDuty [2],
  output logic [CNT_W-1:0]      shOff,
  output logic                  irqOut
);
  logic modeR;
  logic tripLatchR;
  logic irqR;
  logic ctrlWr;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  // shadow register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeR     <= 1'b0;
      shPer[0]  <= '0;
      shPer[1]  <= '0;
      shDuty[0] <= '0;
      shDuty[1] <= '0;
      shOff     <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL:  modeR     <= wrData[BIT_MODE];
        ADDR_PER0:  shPer[0]  <= wrData;
        ADDR_DUTY0: shDuty[0] <= wrData;
        ADDR_PER1:  shPer[1]  <= wrData;
        ADDR_DUTY1: shDuty[1] <= wrData;
        ADDR_OFFS:  shOff     <= wrData;
        default: ;
      endcase
    end
  end

  // fault latch: a live trip has priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      tripLatchR <= 1'b0;
    else if (tripIn)
      tripLatchR <= 1'b1;
    else if (ctrlWr && wrData[BIT_CLR_TRIP])
      tripLatchR <= 1'b0;
  end

  // sticky interrupt: a wrap has priority over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      irqR <= 1'b0;
    else if (leadWrap)
      irqR <= 1'b1;
    else if (ctrlWr && wrData[BIT_CLR_IRQ])
      irqR <= 1'b0;
  end

  assign ctl.offsetMode = modeR;
  assign ctl.shutdown   = tripIn | tripLatchR;
  assign irqOut         = irqR;
endmodule

// File: rtl/auxPwmDatapath.sv
`timescale 1ns/1ps
module auxPwmDatapath
  import auxPwmPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  auxCtl_t               ctl,
  input  logic [CNT_W-1:0]      shPer [2],
  input  logic [CNT_W-1:0]      shDuty [2],
  input  logic [CNT_W-1:0]      shOff,
  output logic [NUM_CH-1:0]     pwmOut,
  output logic                  leadWrap,
  output logic                  leadStart
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  leadNext;
  logic [CNT_W-1:0]  offR;
  logic [NUM_CH-1:0] pwmRaw;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : chanG
    logic [CNT_W-1:0] countR;
    logic [CNT_W-1:0] perR;
    logic [CNT_W-1:0] dutyR;
    logic [CNT_W-1:0] limit;
    logic             restart;
    logic             wrapNow;

    if (ch == 0) begin : leadG
      assign limit   = perR;
      assign restart = 1'b0;
    end else begin : followG
      // offset mode borrows the lead period and realigns to the lead count
      assign limit   = ctl.offsetMode ? chanG[0].perR : perR;
      assign restart = ctl.offsetMode && (leadNext == offR);
    end

    assign wrapNow = restart || (countR >= limit);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        countR <= '0;
        perR   <= '0;
        dutyR  <= '0;
      end else if (wrapNow) begin
        countR <= '0;
        perR   <= shPer[ch];
        dutyR  <= shDuty[ch];
      end else begin
        countR <= countR + ONE;
      end
    end

    assign pwmRaw[ch] = countR < dutyR;
  end

  assign leadWrap  = chanG[0].wrapNow;
  assign leadNext  = leadWrap ? '0 : chanG[0].countR + ONE;
  assign leadStart = (chanG[0].countR == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      offR <= '0;
    else if (leadWrap)
      offR <= shOff;
  end

  assign pwmOut = ctl.shutdown ? '0 : pwmRaw;
endmodule

// File: rtl/auxPwmPair.sv
`timescale 1ns/1ps
module auxPwmPair
  import auxPwmPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              tripIn,
  output logic              pwm0,
  output logic              pwm1,
  output logic              syncOut,
  output logic              irqOut
);
  auxCtl_t          ctl;
  logic [CNT_W-1:0] shPer [2];
  logic [CNT_W-1:0] shDuty [2];
  logic [CNT_W-1:0] shOff;
  logic [1:0]       pwmVec;
  logic             leadWrap;

  auxPwmCtrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tripIn(tripIn), .leadWrap(leadWrap), .ctl(ctl), .shPer(shPer),
    .shDuty(shDuty), .shOff(shOff), .irqOut(irqOut)
  );

  auxPwmDatapath #(.CNT_W(CNT_W), .NUM_CH(2)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shPer(shPer), .shDuty(shDuty),
    .shOff(shOff), .pwmOut(pwmVec), .leadWrap(leadWrap), .leadStart(syncOut)
  );

  assign pwm0 = pwmVec[0];
  assign pwm1 = pwmVec[1];
endmodule

// File: rtl/auxPwmPair_chk.sv
`timescale 1ns/1ps
module auxPwmPair_chk (
  input logic clk,
  input logic rstN,
  input logic tripIn,
  input logic pwm0,
  input logic pwm1,
  input logic syncOut,
  input logic irqOut,
  input logic clrIrqWr
);
  // R9
  trip_force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |-> (!pwm0 && !pwm1));

  // R9
  trip_hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    tripIn |=> (!pwm0 && !pwm1));

  // R8
  irq_on_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(syncOut) |-> irqOut);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !clrIrqWr) |=> irqOut);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> syncOut);
endmodule

bind auxPwmPair auxPwmPair_chk chk_i (
  .clk(clk), .rstN(rstN), .tripIn(tripIn), .pwm0(pwm0), .pwm1(pwm1),
  .syncOut(syncOut), .irqOut(irqOut),
  .clrIrqWr(wrEn && (wrAddr == 3'd0) && wrData[0])
);

// File: tb/auxPwmPair_tb.sv
`timescale 1ns/1ps
module auxPwmPair_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rstN;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [15:0] wrData;
  logic        tripIn;
  logic        pwm0, pwm1, syncOut, irqOut;

  int total = 0;
  int bad   = 0;

  auxPwmPair dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .tripIn(tripIn), .pwm0(pwm0), .pwm1(pwm1), .syncOut(syncOut), .irqOut(irqOut)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrReg(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a[2:0]; wrData = d[15:0];
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at a falling edge where sync is high (k = 0)
  task automatic waitSync();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (syncOut) return;
    end
    chk(1'b0, "R7 sync missing", 0, 1);
  endtask

  function automatic bit expOn(int k, int off, int per, int duty);
    int m = per + 1;
    int ph = (((k - off) % m) + m) % m;
    return ph < duty;
  endfunction

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit s1 [24];
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; tripIn = 1'b0;
    idle(3);
    // R1 reset values
    chk(pwm0 == 1'b0, "R1 pwm0 in reset", pwm0, 0);
    chk(pwm1 == 1'b0, "R1 pwm1 in reset", pwm1, 0);
    chk(irqOut == 1'b0, "R1 irq in reset", irqOut, 0);
    chk(syncOut == 1'b1, "R1 sync in reset", syncOut, 1);
    rstN = 1'b1;
    idle(4);
    chk(pwm0 == 1'b0 && pwm1 == 1'b0, "R1 zero duty after release", pwm0 + pwm1, 0);

    // R3 R5 R7 independent-mode sweep
    for (int p = 1; p <= 5; p++) begin
      for (int d = 0; d <= p + 2; d++) begin
        int q = ((p + d) % 4) + 1;
        int e = d % (q + 2);
        int ones = 0;
        bit perOk = 1'b1;
        wrReg(1, p); wrReg(2, d); wrReg(3, q); wrReg(4, e);
        idle(14);
        waitSync();
        for (int k = 0; k < 24; k++) begin
          if (k > 0) @(negedge clk);
          chk(pwm0 == expOn(k, 0, p, d), "R3 pwm0 pattern", pwm0, expOn(k, 0, p, d));
          chk(syncOut == ((k % (p + 1)) == 0), "R7 sync timing", syncOut, (k % (p + 1)) == 0);
          s1[k] = pwm1;
        end
        for (int k = 0; k <= q; k++) ones += s1[k];
        for (int k = 0; k < 24 - (q + 1); k++) if (s1[k] != s1[k + q + 1]) perOk = 1'b0;
        chk(ones == ((e < q + 1) ? e : q + 1), "R5 ch1 high count", ones, (e < q + 1) ? e : q + 1);
        chk(perOk, "R5 ch1 repeat period", perOk, 1);
      end
    end

    // R4 shadow duty takes effect only at the next wrap
    wrReg(1, 4); wrReg(2, 2);
    idle(14);
    waitSync();
    wrEn = 1'b1; wrAddr = 3'd2; wrData = 16'd5;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1) wrEn = 1'b0;
      chk(pwm0 == ((k < 5) ? (k < 2) : 1'b1), "R4 shadow load timing", pwm0, (k < 5) ? (k < 2) : 1);
    end

    // R2 R6 offset-mode sweep
    wrReg(0, 16);
    for (int p = 2; p <= 5; p++) begin
      for (int o = 0; o <= p; o++) begin
        for (int e = 0; e <= p + 1; e++) begin
          wrReg(1, p); wrReg(2, 1); wrReg(3, 1); wrReg(4, e); wrReg(5, o);
          idle(20);
          waitSync();
          for (int k = 0; k <= 2 * p + 1; k++) begin
            if (k > 0) @(negedge clk);
            chk(pwm1 == expOn(k, o, p, e), "R6 offset ch1 pattern", pwm1, expOn(k, o, p, e));
          end
        end
      end
    end

    // R8 interrupt clear and set priority
    wrReg(1, 4);
    idle(14);
    waitSync();
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 16'h0011;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k == 1 || k == 10) wrEn = 1'b0;
      chk(irqOut == (k >= 5), "R8 irq clear and set", irqOut, k >= 5);
      if (k == 9) begin
        wrEn = 1'b1; wrAddr = 3'd0; wrData = 16'h0011;
      end
    end

    // R9 R10 trip shutdown, latch, recovery in phase
    wrReg(1, 4); wrReg(2, 3); wrReg(4, 2); wrReg(5, 1);
    idle(20);
    waitSync();
    chk(pwm0 == 1'b1, "R10 pre-trip pwm0", pwm0, 1);
    tripIn = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 11) wrEn = 1'b0;
      chk(syncOut == ((k % 5) == 0), "R10 sync runs during trip", syncOut, (k % 5) == 0);
      if (k <= 10) begin
        chk(pwm0 == 1'b0 && pwm1 == 1'b0, (k <= 3) ? "R9 trip forces low" : "R9 latch holds low",
            pwm0 + pwm1, 0);
      end else begin
        chk(pwm0 == expOn(k, 0, 4, 3), "R10 pwm0 phase after clear", pwm0, expOn(k, 0, 4, 3));
        chk(pwm1 == expOn(k, 1, 4, 2), "R10 pwm1 phase after clear", pwm1, expOn(k, 1, 4, 2));
      end
      if (k == 3) tripIn = 1'b0;
      if (k == 10) begin
        wrEn = 1'b1; wrAddr = 3'd0; wrData = 16'h0012;
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule